// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `N` bits (4 by default) over several clock cycles using a single adder. One register holds the multiplicand. A second register holds the multiplier, and its bits are shifted out as they are consumed, so by the end it holds the low half of the product. An accumulator register builds up the partial product and ends up holding the high half. A carry flip-flop keeps the adder's carry-out until the next shift moves it into the accumulator.

A down-counter tracks how many multiplier bits remain. Two state flip-flops drive a 2-to-4 decoder, and the decoded timing lines control the datapath. One line is idle/load, one is the conditional add, one is shift and decrement, and one is done. The accumulator is a universal register with a single mode line: mode 1 loads it in parallel from the adder, and mode 0 shifts it right by one place.

A caller pulses `start_i` with the operands present and waits for `done_o`. The product is then read from `product_o`. It stays valid until the next start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the sequencer returns to idle and every register clears. After reset `done_o` is 0 and `product_o` is 0.
- R2: In the idle or done state, a high `start_i` at a clock edge captures both operands, clears the accumulator and the carry, and loads the bit counter with `N`. `done_o` is 0 after that edge.
- R3: When `done_o` is high, `product_o` equals the unsigned product of the captured operands. The high `N` bits come from the accumulator and the low `N` bits from the multiplier register. In an add step where the multiplier LSB is 0, the accumulator keeps its value.
- R4: Each multiplier bit takes exactly one add step and one shift step, and the counter decreases by one on every shift step. `done_o` is still 0 after edge `2N` and rises after edge `2N+1`, counting the start edge as edge 1 (edge 9 for `N` = 4).
- R5: After `done_o` rises, both `done_o` and `product_o` stay unchanged until the next `start_i`, even when the operand inputs change.
- R6: A `start_i` pulse during the add or shift steps is ignored. The running product and its completion edge are unaffected.
- R7: A `start_i` pulse in the done state begins a new multiplication with the newly presented operands.
- R8: Boundary operands give the correct result: a zero multiplier, a zero multiplicand, and all-ones times all-ones (225 for `N` = 4).
- R9: The operands 1011 and 1001 give 01100011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication (accepted when idle or done) |
| multiplicand_i | input | N | Multiplicand operand |
| multiplier_i | input | N | Multiplier operand |
| product_o | output | 2N | Product: accumulator (high half) and multiplier register (low half) |
| done_o | output | 1 | Product valid |

## Verification
The product is due at a fixed latency. The bench drives `start_i` on a falling edge and counts the rising edges from the one that samples it. It checks that `done_o` is still low after edge eight and is high with the correct product after edge nine. All samples are taken on falling edges, so each one falls between two rising edges.

The same count also covers three cases. Start pulses injected in the middle of a run must not move edge nine. A start pulse in the done state must clear `done_o` after one edge. The hold check looks at the product for twenty cycles after completion while the operand inputs change.

// File: rtl/shift_add_pkg.sv
package shift_add_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_TLINES = 4;
endpackage

// File: rtl/shift_add_ctrl.sv
module shift_add_ctrl
  import shift_add_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  output logic [NUM_TLINES-1:0] tline_o,
  output logic                  load_o
);
  localparam int unsigned CW = $clog2(N + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign load_o = (tline_o[ST_IDLE] | tline_o[ST_DONE]) & start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_ADD;
          cnt_q   <= CW'(N);
        end
        ST_ADD: state_q <= ST_SHIFT;
        ST_SHIFT: begin
          cnt_q   <= cnt_q - CW'(1);
          state_q <= (cnt_q == CW'(1)) ? ST_DONE : ST_ADD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // 2-to-4 decoder of the state flip-flops
  for (genvar i = 0; i < NUM_TLINES; i++) begin : g_dec
    assign tline_o[i] = (state_q == seq_state_e'(i));
  end

  assert_tline_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tline_o) == 1);

  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tline_o[ST_SHIFT] |=> cnt_q == $past(cnt_q) - CW'(1));

  assert_busy_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tline_o[ST_ADD] && start_i) |=> tline_o[ST_SHIFT]);

  assert_load_cnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (cnt_q == CW'(N)) && tline_o[ST_ADD]);
endmodule

// File: rtl/shift_add_acc.sv
module shift_add_acc #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         mode_i,   // 1: parallel load, 0: shift right
  input  logic [N-1:0] par_i,
  input  logic         ser_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (en_i)  q_o <= mode_i ? par_i : {ser_i, q_o[N-1:1]};
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shift_add_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   multiplicand_i,
  input  logic [N-1:0]   multiplier_i,
  output logic [2*N-1:0] product_o,
  output logic           done_o
);
  logic [NUM_TLINES-1:0] tline;
  logic                  load;
  logic [N-1:0]          b_q, c_q, a_q;
  logic                  carry_q;
  logic [N:0]            sum;
  logic                  do_add, do_shift;

  shift_add_ctrl #(.N(N)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tline_o (tline),
    .load_o  (load)
  );

  assign sum      = {1'b0, a_q} + {1'b0, b_q};
  assign do_add   = tline[ST_ADD] & c_q[0];
  assign do_shift = tline[ST_SHIFT];

  shift_add_acc #(.N(N)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .en_i   (do_add | do_shift),
    .mode_i (tline[ST_ADD]),
    .par_i  (sum[N-1:0]),
    .ser_i  (carry_q),
    .q_o    (a_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q     <= '0;
      c_q     <= '0;
      carry_q <= 1'b0;
    end else if (load) begin
      b_q     <= multiplicand_i;
      c_q     <= multiplier_i;
      carry_q <= 1'b0;
    end else if (do_add) begin
      carry_q <= sum[N];
    end else if (do_shift) begin
      c_q     <= {a_q[0], c_q[N-1:1]};
      carry_q <= 1'b0;
    end
  end

  assign product_o = {a_q, c_q};
  assign done_o    = tline[ST_DONE];

  assert_add_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tline[ST_ADD] && !c_q[0]) |=> $stable(a_q) && !carry_q);

  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(product_o));

  assert_load_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (a_q == '0) && !carry_q && !done_o);

  assert_shift_feed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_shift |=> (c_q[N-1] == $past(a_q[0])) && (a_q[N-1] == $past(carry_q)));
endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb_top;
  localparam int unsigned N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic [2*N-1:0] prod;
  logic           done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shift_add_mul #(.N(N)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .multiplicand_i (mcand),
    .multiplier_i   (mplier),
    .product_o      (prod),
    .done_o         (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One multiplication; poke=1 injects start pulses with other operands mid-run.
  task automatic run_mul(input int a, input int b, input bit poke, input string req);
    int exp = a * b;
    @(negedge clk);
    mcand = N'(a); mplier = N'(b); start = 1'b1;
    @(posedge clk);                       // edge 1
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2/R7 done low after start", int'(done), 0);
    for (int e = 2; e <= 8; e++) begin
      if (poke && (e == 3 || e == 6)) begin
        mcand = N'(a + 5); mplier = N'(b + 3); start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b0, "R4 done low after edge 8", int'(done), 0);
    @(posedge clk);                       // edge 9
    @(negedge clk);
    check(done == 1'b1, "R4 done high after edge 9", int'(done), 1);
    check(int'(prod) == exp, req, int'(prod), exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(prod == '0, "R1 reset product", int'(prod), 0);
  endtask

  task automatic test_example();
    run_mul(11, 9, 1'b0, "R9 1011 x 1001");
    check(prod == 8'b0110_0011, "R9 bit pattern", int'(prod), 99);
  endtask

  task automatic test_bounds();
    run_mul(13, 0, 1'b0, "R8 zero multiplier");
    run_mul(0, 14, 1'b0, "R8 zero multiplicand");
    run_mul(15, 15, 1'b0, "R8 all ones");
  endtask

  task automatic test_hold();
    logic [2*N-1:0] snap;
    run_mul(7, 6, 1'b0, "R3 before hold");
    snap = prod;
    for (int i = 0; i < 20; i++) begin
      mcand = N'(i); mplier = N'(~i);
      @(negedge clk);
    end
    check(done == 1'b1, "R5 done held", int'(done), 1);
    check(prod == snap, "R5 product held", int'(prod), int'(snap));
  endtask

  task automatic test_busy();
    run_mul(10, 12, 1'b1, "R6 busy start ignored");
  endtask

  task automatic test_restart();
    run_mul(3, 5, 1'b0, "R7 first");
    run_mul(9, 14, 1'b0, "R7 restart from done");
  endtask

  task automatic test_all();
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++)
        run_mul(a, b, 1'b0, "R3 exhaustive product");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_reset();
    test_example();
    test_bounds();
    test_hold();
    test_busy();
    test_restart();
    test_all();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule